// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a pipelined signed arithmetic slice for filter, correlator and error-coding datapaths. A 27-bit pre-adder combines the D input with a second operand, and that second operand comes from either the A or the B input. The pre-adder result drives a two's-complement 27x18 multiplier. On the 18-bit side the multiplier takes either the B input or, in squaring mode, a narrowed copy of the pre-adder result. The product, sign-extended to 48 bits, enters a three-operand adder whose operands come from the X, Z and W selectors. The W selector can feed back the result register for accumulation, or inject the C input or a rounding constant.

The same X and Z operands that reach the adder also feed a 96-bit parity tree. The tree reports XOR reductions over lanes of 12, 24, 48 or 96 bits. This lets one slice act as a parity or CRC accelerator. Every stage advances on a shared clock enable and clears on a synchronous reset.

Top module: `premac_slice`

## Requirements
- R1: A synchronous reset clears all three pipeline stages whatever the clock enable is. The cycle after a reset edge shows `p_o` = 0 and `xor_o` = 0, and vectors taken under reset never reach the outputs.
- R2: A vector presented at a rising edge with `ce_i` high first shows on `p_o` and `xor_o` after the third such edge. With `ce_i` low, all three stages hold and the outputs do not change.
- R3: The pre-adder works in 27-bit wrap-around arithmetic. The second operand S is A when `pre_src_i`=0 and B sign-extended to 27 bits when `pre_src_i`=1. `pre_mode_i` selects the result: 0 passes A, 1 gives D+S, 2 gives D-S, 3 gives S-D.
- R4: The multiplier treats the pre-adder result and its 18-bit operand as two's-complement numbers. It sign-extends the 45-bit product to 48 bits.
- R5: With `square_i`=1, B is ignored and the 18-bit multiplier operand comes from the pre-adder result. With `sq_clip_i`=0 it is the low 18 bits read as signed. With `sq_clip_i`=1 it is the result saturated to the range -131072..131071, so the product is never negative.
- R6: `p_o` = X + Z + W modulo 2^48. `xsel_i` selects X: 0 zero, 1 product, 2 the zero-extended concatenation {A,B} with A in the upper bits, 3 the negated product. `zsel_i` selects Z: 0 zero, 1 the current `p_o`, 2 C, 3 the negated C.
- R7: `wsel_i` selects W: 0 zero, 1 the current `p_o` (accumulate), 2 C, 3 the rounding constant 2^16.
- R8: The XOR vector is {Z, X}, with Z in bits 95:48. Lane width is 12 << `xor_mode_i` and the lane count is 8 >> `xor_mode_i`. `xor_o[i]` is the XOR reduction of lane i, lane i covers bits i*width upward, and output bits beyond the lane count are zero. `xor_o` follows the same latency as `p_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Shared clock enable for all stages |
| a_i | input | 27 | A operand |
| b_i | input | 18 | B operand |
| c_i | input | 48 | C operand |
| d_i | input | 27 | D operand |
| pre_mode_i | input | 2 | Pre-adder function |
| pre_src_i | input | 1 | Pre-adder second operand: 0 A, 1 B |
| square_i | input | 1 | Squaring mode |
| sq_clip_i | input | 1 | Squaring narrowing: 0 truncate, 1 saturate |
| xsel_i | input | 2 | X operand select |
| zsel_i | input | 2 | Z operand select |
| wsel_i | input | 2 | W operand select |
| xor_mode_i | input | 2 | XOR lane width select |
| p_o | output | 48 | Result register |
| xor_o | output | 8 | Lane parity results |

## Verification
The assertions expect the clock enable and every control field to be known on each rising edge once reset is released. They also treat reset as an event that may come at any time, with or without `ce_i`. The clipped-square property assumes that nothing but the pipeline drives the multiplier register, so no operand values are excluded. The stimulus drives all inputs from defined values on the falling edge, covers every code of each selector, and also sends unconstrained random operands and control fields through the pipeline.

// File: rtl/premac_pkg.sv
package premac_pkg;

   typedef enum logic [1:0] {
      PRE_PASS_A    = 2'd0,
      PRE_D_PLUS_S  = 2'd1,
      PRE_D_MINUS_S = 2'd2,
      PRE_S_MINUS_D = 2'd3
   } pre_mode_e;

   typedef enum logic [1:0] {
      XS_ZERO     = 2'd0,
      XS_PROD     = 2'd1,
      XS_CONCAT   = 2'd2,
      XS_NEG_PROD = 2'd3
   } xsel_e;

   typedef enum logic [1:0] {
      ZS_ZERO  = 2'd0,
      ZS_P     = 2'd1,
      ZS_C     = 2'd2,
      ZS_NEG_C = 2'd3
   } zsel_e;

   typedef enum logic [1:0] {
      WS_ZERO = 2'd0,
      WS_P    = 2'd1,
      WS_C    = 2'd2,
      WS_RND  = 2'd3
   } wsel_e;

   typedef struct packed {
      xsel_e      xs;
      zsel_e      zs;
      wsel_e      ws;
      logic [1:0] xmode;
   } alu_ctrl_t;

   typedef struct packed {
      pre_mode_e pm;
      logic      src_b;
      logic      square;
      logic      clip;
      alu_ctrl_t alu;
   } slice_ctrl_t;

endpackage

// File: rtl/premac_preadd.sv
module premac_preadd
   import premac_pkg::*;
#(
   parameter int AW  = 27,
   parameter int BW  = 18,
   parameter int MAW = 27
) (
   input  logic [AW-1:0]  a_i,
   input  logic [BW-1:0]  b_i,
   input  logic [MAW-1:0] d_i,
   input  pre_mode_e      mode_i,
   input  logic           src_b_i,
   output logic [MAW-1:0] pre_o
);

   logic [MAW-1:0] a_ext;
   logic [MAW-1:0] b_ext;
   logic [MAW-1:0] s_op;

   if (AW > MAW) begin : g_bad_aw
      $error("premac_preadd: AW must not exceed MAW");
   end
   if (BW >= MAW) begin : g_bad_bw
      $error("premac_preadd: BW must be below MAW");
   end

   // widen A only when it is narrower than the pre-adder
   if (AW < MAW) begin : g_a_widen
      assign a_ext = {{(MAW-AW){a_i[AW-1]}}, a_i};
   end else begin : g_a_direct
      assign a_ext = a_i;
   end

   assign b_ext = {{(MAW-BW){b_i[BW-1]}}, b_i};
   assign s_op  = src_b_i ? b_ext : a_ext;

   always_comb begin
      unique case (mode_i)
         PRE_PASS_A:    pre_o = a_ext;
         PRE_D_PLUS_S:  pre_o = d_i + s_op;
         PRE_D_MINUS_S: pre_o = d_i - s_op;
         PRE_S_MINUS_D: pre_o = s_op - d_i;
         default:       pre_o = a_ext;
      endcase
   end

endmodule

// File: rtl/premac_mult.sv
module premac_mult #(
   parameter int MAW = 27,
   parameter int BW  = 18,
   parameter int PW  = 48
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           ce_i,
   input  logic [MAW-1:0] pre_i,
   input  logic [BW-1:0]  b_i,
   input  logic           square_i,
   input  logic           clip_i,
   output logic [PW-1:0]  m_o
);

   localparam int HB = MAW - BW + 1;

   logic [HB-1:0] top_bits;
   logic          fits;
   logic [BW-1:0] sat_val;
   logic [BW-1:0] sq_op;
   logic [BW-1:0] mb_op;
   logic [PW-1:0] ea;
   logic [PW-1:0] eb;
   logic [PW-1:0] m_q;

   if (PW < MAW + BW) begin : g_bad_pw
      $error("premac_mult: PW too narrow for the full product");
   end

   // saturation: pre fits when every bit above the signed range matches
   assign top_bits = pre_i[MAW-1:BW-1];
   assign fits     = (&top_bits) | ~(|top_bits);
   assign sat_val  = fits ? pre_i[BW-1:0]
                          : {pre_i[MAW-1], {(BW-1){~pre_i[MAW-1]}}};
   assign sq_op    = clip_i ? sat_val : pre_i[BW-1:0];
   assign mb_op    = square_i ? sq_op : b_i;

   assign ea = {{(PW-MAW){pre_i[MAW-1]}}, pre_i};
   assign eb = {{(PW-BW){mb_op[BW-1]}}, mb_op};

   always_ff @(posedge clk_i) begin
      if (rst_i)     m_q <= '0;
      else if (ce_i) m_q <= ea * eb;
   end

   assign m_o = m_q;

   AST_SQ_NONNEG: assert property (@(posedge clk_i) disable iff (rst_i)
      (ce_i && square_i && clip_i) |=> !m_q[PW-1]); // R5

endmodule

// File: rtl/premac_alu.sv
module premac_alu
   import premac_pkg::*;
#(
   parameter int PW      = 48,
   parameter int RND_POS = 16
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            ce_i,
   input  logic [PW-1:0]   m_i,
   input  logic [PW-1:0]   cat_i,
   input  logic [PW-1:0]   c_i,
   input  alu_ctrl_t       ctrl_i,
   output logic [PW-1:0]   p_o,
   output logic [2*PW-1:0] xvec_o
);

   localparam logic [PW-1:0] RND_K = {{(PW-1){1'b0}}, 1'b1} << RND_POS;

   logic [PW-1:0] x_op;
   logic [PW-1:0] z_op;
   logic [PW-1:0] w_op;
   logic [PW-1:0] p_q;

   if (RND_POS >= PW) begin : g_bad_rnd
      $error("premac_alu: RND_POS outside the result width");
   end

   always_comb begin
      unique case (ctrl_i.xs)
         XS_ZERO:     x_op = '0;
         XS_PROD:     x_op = m_i;
         XS_CONCAT:   x_op = cat_i;
         XS_NEG_PROD: x_op = -m_i;
         default:     x_op = '0;
      endcase
      unique case (ctrl_i.zs)
         ZS_ZERO:  z_op = '0;
         ZS_P:     z_op = p_q;
         ZS_C:     z_op = c_i;
         ZS_NEG_C: z_op = -c_i;
         default:  z_op = '0;
      endcase
      unique case (ctrl_i.ws)
         WS_ZERO: w_op = '0;
         WS_P:    w_op = p_q;
         WS_C:    w_op = c_i;
         WS_RND:  w_op = RND_K;
         default: w_op = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)     p_q <= '0;
      else if (ce_i) p_q <= x_op + z_op + w_op;
   end

   assign p_o    = p_q;
   assign xvec_o = {z_op, x_op};

   AST_CE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !ce_i |=> $stable(p_q)); // R2

   AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (ce_i && ctrl_i.xs == XS_PROD && ctrl_i.zs == ZS_ZERO && ctrl_i.ws == WS_P)
      |=> p_q == $past(p_q + m_i)); // R7

endmodule

// File: rtl/premac_xor.sv
module premac_xor #(
   parameter int PW   = 48,
   parameter int LANE = 12
) (
   input  logic [2*PW-1:0]          vec_i,
   input  logic [1:0]               mode_i,
   output logic [(2*PW/LANE)-1:0]   par_o
);

   localparam int NV = 2 * PW;
   localparam int NL = NV / LANE;
   localparam int NM = $clog2(NL) + 1;

   logic [NM-1:0][NL-1:0] lvl;

   if (NL * LANE != NV) begin : g_bad_lane
      $error("premac_xor: lane width must divide the vector");
   end
   if ((1 << (NM - 1)) != NL) begin : g_bad_count
      $error("premac_xor: lane count must be a power of two");
   end
   if (NM > 4) begin : g_bad_modes
      $error("premac_xor: more widths than the mode field encodes");
   end

   // level 0: parity of each narrowest lane
   for (genvar i = 0; i < NL; i++) begin : g_leaf
      assign lvl[0][i] = ^vec_i[i*LANE +: LANE];
   end

   // each wider level folds adjacent pairs of the level below
   for (genvar m = 1; m < NM; m++) begin : g_level
      for (genvar i = 0; i < NL; i++) begin : g_node
         if (i < (NL >> m)) begin : g_used
            assign lvl[m][i] = lvl[m-1][2*i] ^ lvl[m-1][2*i+1];
         end else begin : g_pad
            assign lvl[m][i] = 1'b0;
         end
      end
   end

   always_comb begin
      par_o = '0;
      for (int m = 0; m < NM; m++) begin
         if (mode_i == m[1:0]) par_o = lvl[m];
      end
   end

endmodule

// File: rtl/premac_slice.sv
module premac_slice
   import premac_pkg::*;
#(
   parameter int AW      = 27,
   parameter int BW      = 18,
   parameter int CW      = 48,
   parameter int DW      = 27,
   parameter int PW      = 48,
   parameter int XLANE   = 12,
   parameter int RND_POS = 16
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    ce_i,
   input  logic [AW-1:0]           a_i,
   input  logic [BW-1:0]           b_i,
   input  logic [CW-1:0]           c_i,
   input  logic [DW-1:0]           d_i,
   input  logic [1:0]              pre_mode_i,
   input  logic                    pre_src_i,
   input  logic                    square_i,
   input  logic                    sq_clip_i,
   input  logic [1:0]              xsel_i,
   input  logic [1:0]              zsel_i,
   input  logic [1:0]              wsel_i,
   input  logic [1:0]              xor_mode_i,
   output logic [PW-1:0]           p_o,
   output logic [(2*PW/XLANE)-1:0] xor_o
);

   localparam int MAW = DW;
   localparam int XL  = 2 * PW / XLANE;
   localparam int CAT = AW + BW;

   if (CW != PW) begin : g_bad_cw
      $error("premac_slice: C width must equal result width");
   end
   if (CAT >= PW) begin : g_bad_cat
      $error("premac_slice: A:B concatenation must fit the result");
   end

   // stage 1: input registers
   logic [AW-1:0]  a_q;
   logic [BW-1:0]  b_q;
   logic [CW-1:0]  c_q;
   logic [DW-1:0]  d_q;
   slice_ctrl_t    ctl_d;
   slice_ctrl_t    ctl_q;

   always_comb begin
      ctl_d.pm        = pre_mode_e'(pre_mode_i);
      ctl_d.src_b     = pre_src_i;
      ctl_d.square    = square_i;
      ctl_d.clip      = sq_clip_i;
      ctl_d.alu.xs    = xsel_e'(xsel_i);
      ctl_d.alu.zs    = zsel_e'(zsel_i);
      ctl_d.alu.ws    = wsel_e'(wsel_i);
      ctl_d.alu.xmode = xor_mode_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         a_q   <= '0;
         b_q   <= '0;
         c_q   <= '0;
         d_q   <= '0;
         ctl_q <= '0;
      end else if (ce_i) begin
         a_q   <= a_i;
         b_q   <= b_i;
         c_q   <= c_i;
         d_q   <= d_i;
         ctl_q <= ctl_d;
      end
   end

   // pre-adder and multiplier (stage 2 register inside the multiplier)
   logic [MAW-1:0] pre_w;
   logic [PW-1:0]  m_w;

   premac_preadd #(.AW(AW), .BW(BW), .MAW(MAW)) preadd_i (
      .a_i     (a_q),
      .b_i     (b_q),
      .d_i     (d_q),
      .mode_i  (ctl_q.pm),
      .src_b_i (ctl_q.src_b),
      .pre_o   (pre_w)
   );

   premac_mult #(.MAW(MAW), .BW(BW), .PW(PW)) mult_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .ce_i     (ce_i),
      .pre_i    (pre_w),
      .b_i      (b_q),
      .square_i (ctl_q.square),
      .clip_i   (ctl_q.clip),
      .m_o      (m_w)
   );

   // stage 2 side registers travelling beside the product
   logic [PW-1:0] cat_q;
   logic [CW-1:0] c2_q;
   alu_ctrl_t     actl_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cat_q  <= '0;
         c2_q   <= '0;
         actl_q <= '0;
      end else if (ce_i) begin
         cat_q  <= {{(PW-CAT){1'b0}}, a_q, b_q};
         c2_q   <= c_q;
         actl_q <= ctl_q.alu;
      end
   end

   // stage 3: ALU with result register, lane parity register
   logic [2*PW-1:0] xvec_w;
   logic [XL-1:0]   par_w;
   logic [XL-1:0]   xor_q;

   premac_alu #(.PW(PW), .RND_POS(RND_POS)) alu_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .ce_i   (ce_i),
      .m_i    (m_w),
      .cat_i  (cat_q),
      .c_i    (c2_q),
      .ctrl_i (actl_q),
      .p_o    (p_o),
      .xvec_o (xvec_w)
   );

   premac_xor #(.PW(PW), .LANE(XLANE)) xor_i (
      .vec_i  (xvec_w),
      .mode_i (actl_q.xmode),
      .par_o  (par_w)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i)     xor_q <= '0;
      else if (ce_i) xor_q <= par_w;
   end

   assign xor_o = xor_q;

   AST_RST_CLEAR: assert property (@(posedge clk_i)
      rst_i |=> (p_o == '0 && xor_o == '0)); // R1

   AST_XOR_PAD: assert property (@(posedge clk_i) disable iff (rst_i)
      (ce_i && actl_q.xmode == 2'd3) |=> xor_o[XL-1:1] == '0); // R8

endmodule

// File: tb/premac_slice_tb_top.sv
`timescale 1ns/1ps
module premac_slice_tb_top;

   typedef struct packed {
      logic [26:0] a;
      logic [17:0] b;
      logic [47:0] c;
      logic [26:0] d;
      logic [1:0]  pm;
      logic        ps;
      logic        sq;
      logic        cl;
      logic [1:0]  xs;
      logic [1:0]  zs;
      logic [1:0]  ws;
      logic [1:0]  xm;
   } vec_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ce  = 1'b0;
   vec_t        vin = '0;
   logic [47:0] p_o;
   logic [7:0]  xor_o;

   int n_vec  = 0;
   int n_fail = 0;

   vec_t        h0 = '0;
   vec_t        h1 = '0;
   logic [47:0] p_exp = '0;
   logic [7:0]  x_exp = '0;

   always #4 clk = ~clk;

   premac_slice dut_i (
      .clk_i      (clk),
      .rst_i      (rst),
      .ce_i       (ce),
      .a_i        (vin.a),
      .b_i        (vin.b),
      .c_i        (vin.c),
      .d_i        (vin.d),
      .pre_mode_i (vin.pm),
      .pre_src_i  (vin.ps),
      .square_i   (vin.sq),
      .sq_clip_i  (vin.cl),
      .xsel_i     (vin.xs),
      .zsel_i     (vin.zs),
      .wsel_i     (vin.ws),
      .xor_mode_i (vin.xm),
      .p_o        (p_o),
      .xor_o      (xor_o)
   );

   // ---------------- reference model ----------------
   function automatic logic signed [47:0] f_prod(vec_t v);
      logic signed [26:0] s, pr;
      logic signed [17:0] mb;
      logic signed [47:0] e1, e2;
      s = v.ps ? {{9{v.b[17]}}, v.b} : v.a;
      case (v.pm)
         2'd0: pr = v.a;
         2'd1: pr = v.d + s;
         2'd2: pr = v.d - s;
         default: pr = s - v.d;
      endcase
      if (!v.sq)          mb = v.b;
      else if (!v.cl)     mb = pr[17:0];
      else if (pr > 27'sd131071)  mb = 18'sd131071;
      else if (pr < -27'sd131072) mb = -18'sd131072;
      else                mb = pr[17:0];
      e1 = pr;
      e2 = mb;
      return e1 * e2;
   endfunction

   function automatic logic [47:0] f_x(vec_t v);
      case (v.xs)
         2'd0: return 48'd0;
         2'd1: return f_prod(v);
         2'd2: return {3'b000, v.a, v.b};
         default: return -f_prod(v);
      endcase
   endfunction

   function automatic logic [47:0] f_z(vec_t v, logic [47:0] p);
      case (v.zs)
         2'd0: return 48'd0;
         2'd1: return p;
         2'd2: return v.c;
         default: return -v.c;
      endcase
   endfunction

   function automatic logic [47:0] f_w(vec_t v, logic [47:0] p);
      case (v.ws)
         2'd0: return 48'd0;
         2'd1: return p;
         2'd2: return v.c;
         default: return 48'd65536;
      endcase
   endfunction

   function automatic logic [7:0] f_xor(vec_t v, logic [47:0] p);
      logic [95:0] vv;
      logic [7:0]  r;
      int w, n;
      vv = {f_z(v, p), f_x(v)};
      w = 12 << v.xm;
      n = 8 >> v.xm;
      r = '0;
      for (int i = 0; i < n; i++) begin
         for (int k = 0; k < w; k++) r[i] = r[i] ^ vv[i*w + k];
      end
      return r;
   endfunction

   function automatic vec_t rv();
      vec_t v;
      v = '0;
      v.a  = 27'($urandom);
      v.b  = 18'($urandom);
      v.c  = {16'($urandom), 32'($urandom)};
      v.d  = 27'($urandom);
      v.pm = 2'($urandom);
      v.ps = 1'($urandom);
      v.sq = 1'($urandom);
      v.cl = 1'($urandom);
      v.xs = 2'($urandom);
      v.zs = 2'($urandom);
      v.ws = 2'($urandom);
      v.xm = 2'($urandom);
      return v;
   endfunction

   // ---------------- drive / check ----------------
   task automatic check(input string req);
      n_vec++;
      if (p_o !== p_exp || xor_o !== x_exp) begin
         n_fail++;
         $display("FAIL %s: p=%h xor=%h expected p=%h xor=%h",
                  req, p_o, xor_o, p_exp, x_exp);
      end
   endtask

   task automatic step(input vec_t v, input logic cev, input string req);
      logic [47:0] np;
      logic [7:0]  nx;
      vin = v;
      ce  = cev;
      if (cev) begin
         np = f_x(h1) + f_z(h1, p_exp) + f_w(h1, p_exp);
         nx = f_xor(h1, p_exp);
         p_exp = np;
         x_exp = nx;
         h1 = h0;
         h0 = v;
      end
      @(posedge clk);
      @(negedge clk);
      check(req);
   endtask

   task automatic do_reset(input vec_t v, input logic cev, input string req);
      rst = 1'b1;
      vin = v;
      ce  = cev;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      h0 = '0;
      h1 = '0;
      p_exp = '0;
      x_exp = '0;
      check(req);
   endtask

   task automatic flush(input string req);
      for (int i = 0; i < 3; i++) step('0, 1'b1, req);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_r1();
      vec_t v;
      v = rv();
      v.xs = 2'd1;
      do_reset(v, 1'b1, "R1 reset with ce high");
      do_reset(rv(), 1'b1, "R1 reset repeated");
      v.zs = 2'd2;
      v.c  = 48'h1234_5678_9abc;
      step(v, 1'b1, "R1 load before reset");
      step(v, 1'b1, "R1 load before reset");
      step(v, 1'b1, "R1 load before reset");
      do_reset(v, 1'b0, "R1 reset with ce low");
      step('0, 1'b1, "R1 nothing leaks after reset");
      step('0, 1'b1, "R1 nothing leaks after reset");
   endtask

   task automatic t_latency_r2();
      vec_t v;
      v = '0;
      v.a = 27'd1000; v.b = 18'd77; v.xs = 2'd1; v.xm = 2'd0;
      step(v, 1'b1, "R2 latency edge 1");
      step('0, 1'b1, "R2 latency edge 2");
      if (p_o !== 48'd0) begin
         n_fail++;
         $display("FAIL R2 early result: p=%h expected 0", p_o);
      end
      n_vec++;
      step('0, 1'b1, "R2 latency edge 3");
      if (p_o !== 48'd77000) begin
         n_fail++;
         $display("FAIL R2 third edge: p=%h expected %h", p_o, 48'd77000);
      end
      n_vec++;
      step('0, 1'b1, "R2 latency drain");
   endtask

   task automatic t_ce_hold_r2();
      vec_t v;
      v = rv();
      v.xs = 2'd1;
      step(v, 1'b1, "R2 fill");
      step(rv(), 1'b1, "R2 fill");
      step(rv(), 1'b1, "R2 fill");
      for (int i = 0; i < 4; i++) step(rv(), 1'b0, "R2 hold with ce low");
      step(rv(), 1'b1, "R2 resume");
      step(rv(), 1'b1, "R2 resume");
      flush("R2 flush");
   endtask

   task automatic t_preadd_r3();
      vec_t v;
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < 2; s++) begin
            v = '0;
            v.a = 27'h7ff_1234; v.b = 18'h2_0345; v.d = 27'd5_000_000;
            v.pm = 2'(m); v.ps = 1'(s); v.xs = 2'd1;
            step(v, 1'b1, "R3 pre-adder mode/source");
         end
      end
      v = '0;
      v.d = 27'h3ff_ffff; v.a = 27'd1; v.b = 18'd1; v.pm = 2'd1; v.xs = 2'd1;
      step(v, 1'b1, "R3 positive wrap");
      v.d = 27'h400_0000; v.pm = 2'd2;
      step(v, 1'b1, "R3 negative wrap");
      flush("R3 flush");
   endtask

   task automatic t_mult_r4();
      vec_t v;
      v = '0; v.xs = 2'd1;
      v.a = 27'h400_0000; v.b = 18'h2_0000;
      step(v, 1'b1, "R4 min times min");
      v.a = 27'h3ff_ffff; v.b = 18'h2_0000;
      step(v, 1'b1, "R4 max times min");
      v.a = 27'h7ff_ffff; v.b = 18'h1_ffff;
      step(v, 1'b1, "R4 -1 times max");
      v.a = 27'd12345; v.b = 18'h3_fffd;
      step(v, 1'b1, "R4 positive times negative");
      flush("R4 flush");
      if (p_o !== 48'd0) begin
         n_fail++;
         $display("FAIL R4 drain: p=%h expected 0", p_o);
      end
      n_vec++;
   endtask

   task automatic t_square_r5();
      vec_t v;
      for (int c = 0; c < 2; c++) begin
         for (int k = 0; k < 3; k++) begin
            v = '0;
            v.sq = 1'b1; v.cl = 1'(c); v.xs = 2'd1; v.pm = 2'd1;
            v.d = 27'd199_000; v.a = 27'd1000;
            v.b = 18'($urandom);
            step(v, 1'b1, "R5 square with B varied");
         end
         v.d = 27'h7f0_0000; v.a = 27'd7; v.pm = 2'd2;
         step(v, 1'b1, "R5 negative square input");
         v.d = 27'd300; v.a = 27'd45; v.pm = 2'd2;
         step(v, 1'b1, "R5 in-range square");
      end
      flush("R5 flush");
   endtask

   task automatic t_alu_r6();
      vec_t v;
      for (int x = 0; x < 4; x++) begin
         for (int z = 0; z < 4; z++) begin
            v = rv();
            v.sq = 1'b0; v.xs = 2'(x); v.zs = 2'(z); v.ws = 2'd0;
            step(v, 1'b1, "R6 X/Z selection");
         end
      end
      v = '0;
      v.c = 48'hffff_ffff_ffff; v.zs = 2'd2; v.ws = 2'd2;
      step(v, 1'b1, "R6 modulo wrap");
      flush("R6 flush");
   endtask

   task automatic t_wmux_r7();
      vec_t v;
      v = '0;
      v.a = 27'd3; v.b = 18'd5; v.xs = 2'd1; v.ws = 2'd1;
      for (int i = 0; i < 6; i++) step(v, 1'b1, "R7 accumulate");
      v.ws = 2'd3;
      step(v, 1'b1, "R7 rounding constant");
      v.ws = 2'd2; v.c = 48'h8000_0000_0001;
      step(v, 1'b1, "R7 C on W");
      v.ws = 2'd0;
      step(v, 1'b1, "R7 zero on W");
      flush("R7 flush");
   endtask

   task automatic t_xor_r8();
      vec_t v;
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 3; k++) begin
            v = rv();
            v.xm = 2'(m);
            step(v, 1'b1, "R8 lane parity");
         end
      end
      flush("R8 flush");
   endtask

   task automatic t_random_all();
      for (int i = 0; i < 300; i++) step(rv(), 1'($urandom % 5 != 0), "R6 R8 random stream");
      flush("R2 random flush");
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      @(negedge clk);
      t_reset_r1();
      t_latency_r2();
      t_ce_hold_r2();
      t_preadd_r3();
      t_mult_r4();
      t_square_r5();
      t_alu_r6();
      t_wmux_r7();
      t_xor_r8();
      t_random_all();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule